// File: doc/BRIEF.md
# Dual-Bank GPIO Register File

This block controls 32 general-purpose pins through a 32-bit register bus. The pins form two banks of sixteen. Pins 0 to 15 are the low bank and pins 16 to 31 are the high bank. Each bank has its own copy of every control register. The high bank's copy sits at a fixed 0x80 byte offset above the low bank's copy.

Every control register is written with a set/clear word, so software can change any group of pins without first reading the register:

- The low half of the written word selects bits to set.
- The high half selects bits to clear.

Each pin has six controls: output value, output enable, input enable, two output alternate-function selects and one input alternate-function select. Each pin also has a readback bit and two edge-capture flags, one for rising edges and one for falling edges. Pad inputs pass through a two-flop synchronizer before they reach the readback path and the edge detectors. Pad drive is modelled as a data output and an enable output for each pin.

Top module: `dual_bank_gpio`

## Requirements
- R1: After reset, every control register, readback bit and edge flag reads 0, and no pad is driven (pad_oe_o and pad_out_o are 0).
- R2: Register byte offsets within a bank are:

  | Offset | Register |
  |--------|----------|
  | 0x00 | output value |
  | 0x04 | output enable |
  | 0x08 | input enable |
  | 0x0C | output alternate 1 |
  | 0x10 | output alternate 2 |
  | 0x14 | input alternate 1 |
  | 0x18 | readback |
  | 0x1C | rising-edge flags |
  | 0x20 | falling-edge flags |

  Bit k of a register at offset A belongs to pin k. The same register at A+0x80 covers pins 16+k. A write to one bank never changes the other bank.
- R3: In a control-register write, a 1 at data bit k (k in 0..15) sets that bank's bit for pin k.
- R4: A 1 at data bit k+16 clears the bit for pin k. When bits k and k+16 are both 1, the clear wins.
- R5: A control-register write leaves unchanged every bit whose set bit and clear bit are both 0.
- R6: A read returns the bank's 16 bits in rdata_o[15:0], with rdata_o[31:16] equal to 0. rvalid_o pulses in the cycle after the read request.
- R7: Pins 23, 29, 30 and 31 are reserved. Their bit reads 0 in every register and flag, and the pad is never driven.
- R8: A pin is driven (pad_oe_o bit = 1) only while its output enable is 1 and both output alternate selects are 0. While the pin is driven, pad_out_o carries its output value; otherwise pad_out_o is 0.
- R9: A readback bit equals the two-flop-synchronized pad input while input enable is 1, and 0 otherwise.
- R10: A rising or falling edge of the synchronized input sets the matching edge flag, but only while input enable is 1.
- R11: Writing 1 to data bit k (k in 0..15) of an edge-flag register clears pin k's flag. The high half of the written word is ignored. A new edge in the same cycle as the clear leaves the flag set.
- R12: Writes to the readback offset, writes to unaligned addresses (address bits [1:0] not 0), and writes to unmapped offsets change nothing. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address; bit 7 selects the high bank |
| wdata_i | input | 32 | Write data: set bits in [15:0], clear bits in [31:16] |
| rdata_o | output | 32 | Read data, registered |
| rvalid_o | output | 1 | Read data valid, one cycle after the read request |
| pad_in_i | input | 32 | Asynchronous pad inputs |
| pad_out_o | output | 32 | Pad output data |
| pad_oe_o | output | 32 | Pad output enable |

## Verification
The hardest case to reach is an edge flag whose clear write and new edge land in the same clock. Three registers lie between the pad and the flag, so the bench changes the pad at a falling clock edge. It then waits exactly two rising edges and drives the clear write, so that the write and the edge event reach the flag register on the same rising edge.

Clear priority in R4 is reached by a single write that sets and clears the same pin. Reserved-pin masking is reached by:
- writing all ones to the high bank;
- toggling pad 23 while input is enabled.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NUM_FEAT = 6;
  // control register slots, also the word index within a bank
  localparam int FI_OUT_VAL  = 0;
  localparam int FI_OUT_EN   = 1;
  localparam int FI_IN_EN    = 2;
  localparam int FI_OUT_ALT1 = 3;
  localparam int FI_OUT_ALT2 = 4;
  localparam int FI_IN_ALT1  = 5;
  localparam int WI_READBACK = 6;
  localparam int WI_RISE     = 7;
  localparam int WI_FALL     = 8;
  localparam logic [31:0] DEF_IMPL_MASK = 32'h1F7F_FFFF;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int               BANK_W = 16,
  parameter int               IDX_W  = 5,
  parameter logic [BANK_W-1:0] IMPL  = '1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_FEAT-1:0] feat_we_i,
  input  logic                rise_clr_i,
  input  logic                fall_clr_i,
  input  logic [2*BANK_W-1:0] wdata_i,
  input  logic [BANK_W-1:0]   pad_sync_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [BANK_W-1:0]   rd_data_o,
  output logic [BANK_W-1:0]   pad_out_o,
  output logic [BANK_W-1:0]   pad_oe_o
);
  logic [BANK_W-1:0] feat_q [NUM_FEAT];
  logic [BANK_W-1:0] set_v, clr_v;
  logic [BANK_W-1:0] in_en, drive, rb;
  logic [BANK_W-1:0] prev_q, rise_q, fall_q;
  logic [BANK_W-1:0] rise_evt, fall_evt;

  assign set_v = wdata_i[BANK_W-1:0] & IMPL;
  assign clr_v = wdata_i[2*BANK_W-1:BANK_W] & IMPL;

  for (genvar g = 0; g < NUM_FEAT; g++) begin : g_feat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           feat_q[g] <= '0;
      else if (feat_we_i[g]) feat_q[g] <= (feat_q[g] | set_v) & ~clr_v;  // clear wins
    end

    a_r3_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (feat_we_i[g] && |(set_v & ~clr_v)) |=>
        ((feat_q[g] & $past(set_v & ~clr_v)) == $past(set_v & ~clr_v)));
    a_r4_clear_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (feat_we_i[g] && |clr_v) |=> ((feat_q[g] & $past(clr_v)) == '0));
    a_r5_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !feat_we_i[g] |=> $stable(feat_q[g]));
    a_r7_reserved_feat: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (feat_q[g] & ~IMPL) == '0);
  end

  assign in_en = feat_q[FI_IN_EN];
  assign rb    = pad_sync_i & in_en & IMPL;

  // edge capture on synchronized input
  assign rise_evt = pad_sync_i & ~prev_q & in_en & IMPL;
  assign fall_evt = ~pad_sync_i & prev_q & in_en & IMPL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      prev_q <= pad_sync_i;
      rise_q <= (rise_q & ~(rise_clr_i ? set_v : '0)) | rise_evt;  // set wins
      fall_q <= (fall_q & ~(fall_clr_i ? set_v : '0)) | fall_evt;
    end
  end

  assign drive     = feat_q[FI_OUT_EN] & ~feat_q[FI_OUT_ALT1] & ~feat_q[FI_OUT_ALT2] & IMPL;
  assign pad_oe_o  = drive;
  assign pad_out_o = feat_q[FI_OUT_VAL] & drive;

  always_comb begin
    case (int'(rd_idx_i))
      FI_OUT_VAL:  rd_data_o = feat_q[FI_OUT_VAL];
      FI_OUT_EN:   rd_data_o = feat_q[FI_OUT_EN];
      FI_IN_EN:    rd_data_o = feat_q[FI_IN_EN];
      FI_OUT_ALT1: rd_data_o = feat_q[FI_OUT_ALT1];
      FI_OUT_ALT2: rd_data_o = feat_q[FI_OUT_ALT2];
      FI_IN_ALT1:  rd_data_o = feat_q[FI_IN_ALT1];
      WI_READBACK: rd_data_o = rb;
      WI_RISE:     rd_data_o = rise_q;
      WI_FALL:     rd_data_o = fall_q;
      default:     rd_data_o = '0;
    endcase
  end

  a_r8_alt_blocks_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & (feat_q[FI_OUT_ALT1] | feat_q[FI_OUT_ALT2])) == '0);
  a_r10_rise_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |rise_evt |=> ((rise_q & $past(rise_evt)) == $past(rise_evt)));
  a_r10_fall_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |fall_evt |=> ((fall_q & $past(fall_evt)) == $past(fall_evt)));
  a_r11_rise_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_clr_i && |(set_v & ~rise_evt)) |=> ((rise_q & $past(set_v & ~rise_evt)) == '0));
  a_r7_reserved_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rise_q | fall_q) & ~IMPL) == '0);
endmodule

// File: rtl/dual_bank_gpio.sv
module dual_bank_gpio
  import gpio_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          HIGH_OFF  = 128,
  parameter logic [31:0] IMPL_MASK = DEF_IMPL_MASK,
  localparam int         HIGH_BIT  = $clog2(HIGH_OFF),
  localparam int         ADDR_W    = HIGH_BIT + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  input  logic [DATA_W-1:0] pad_in_i,
  output logic [DATA_W-1:0] pad_out_o,
  output logic [DATA_W-1:0] pad_oe_o
);
  localparam int BANK_W   = DATA_W / 2;
  localparam int NUM_BANK = 2;
  localparam int WORD_LSB = $clog2(DATA_W / 8);
  localparam int IDX_W    = HIGH_BIT - WORD_LSB;

  logic [DATA_W-1:0] pad_sync;
  logic [IDX_W-1:0]  word_idx;
  logic              aligned, bank_sel, wr_hit;
  logic [BANK_W-1:0] bank_rd [NUM_BANK];
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  assign word_idx = addr_i[HIGH_BIT-1:WORD_LSB];
  assign aligned  = (addr_i[WORD_LSB-1:0] == '0);
  assign bank_sel = addr_i[HIGH_BIT];
  assign wr_hit   = req_i & we_i & aligned;

  gpio_sync #(.W(DATA_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (pad_sync)
  );

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic                bank_hit;
    logic [NUM_FEAT-1:0] feat_we;

    assign bank_hit = wr_hit && (bank_sel == b[0]);
    for (genvar k = 0; k < NUM_FEAT; k++) begin : g_we
      assign feat_we[k] = bank_hit && (int'(word_idx) == k);
    end

    gpio_bank #(
      .BANK_W(BANK_W),
      .IDX_W (IDX_W),
      .IMPL  (IMPL_MASK[b*BANK_W +: BANK_W])
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .feat_we_i (feat_we),
      .rise_clr_i(bank_hit && (int'(word_idx) == WI_RISE)),
      .fall_clr_i(bank_hit && (int'(word_idx) == WI_FALL)),
      .wdata_i   (wdata_i),
      .pad_sync_i(pad_sync[b*BANK_W +: BANK_W]),
      .rd_idx_i  (word_idx),
      .rd_data_o (bank_rd[b]),
      .pad_out_o (pad_out_o[b*BANK_W +: BANK_W]),
      .pad_oe_o  (pad_oe_o[b*BANK_W +: BANK_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= req_i & ~we_i;
      if (req_i && !we_i)
        rdata_q <= aligned ? {{BANK_W{1'b0}}, bank_rd[bank_sel]} : '0;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  a_r6_read_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  a_r6_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (rdata_o[DATA_W-1:BANK_W] == '0));
  a_r7_reserved_pads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~IMPL_MASK[DATA_W-1:0]) == '0);
endmodule

// File: tb/tb_dual_bank_gpio.sv
module tb_dual_bank_gpio;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  dual_bank_gpio dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    item_t it;
    @(negedge clk);
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pop and compare on each returned read
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (sb_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R6: unexpected rvalid, got 0x%08h expected none", rdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, rdata, it.exp);
      end
    end
  end

  initial begin
    #(10 * 50000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    check("R1 pad_oe reset", pad_oe, 32'h0);
    check("R1 pad_out reset", pad_out, 32'h0);
    check("R1 rdata reset", rdata, 32'h0);
    for (int i = 0; i < 9; i++) begin
      rd(8'(4 * i), 32'h0, "R1 low bank reset");
      rd(8'(8'h80 + 4 * i), 32'h0, "R1 high bank reset");
    end

    // set / clear encoding
    wr(8'h04, 32'h0000_00FF);
    rd(8'h04, 32'h0000_00FF, "R3 set bits");
    wr(8'h04, 32'h000F_0000);
    rd(8'h04, 32'h0000_00F0, "R4 clear bits");
    wr(8'h04, 32'h0000_0000);
    rd(8'h04, 32'h0000_00F0, "R5 zero write holds");
    wr(8'h04, 32'h0010_0030);
    rd(8'h04, 32'h0000_00E0, "R4 clear beats set");
    wr(8'h14, 32'h0000_0003);
    rd(8'h14, 32'h0000_0003, "R3 input alt1 set");

    // pad drive
    wr(8'h00, 32'h0000_00A0);
    check("R8 oe from enable", pad_oe, 32'h0000_00E0);
    check("R8 out value", pad_out, 32'h0000_00A0);
    wr(8'h0C, 32'h0000_0020);
    check("R8 alt1 blocks oe", pad_oe, 32'h0000_00C0);
    check("R8 alt1 blocks out", pad_out, 32'h0000_0080);
    wr(8'h10, 32'h0000_0080);
    check("R8 alt2 blocks oe", pad_oe, 32'h0000_0040);
    check("R8 alt2 blocks out", pad_out, 32'h0000_0000);

    // high bank and reserved pins
    wr(8'h84, 32'h0000_FFFF);
    rd(8'h84, 32'h0000_1F7F, "R7 R2 high bank reserved masked");
    check("R7 reserved pads undriven", pad_oe, 32'h1F7F_0040);
    rd(8'h04, 32'h0000_00E0, "R2 low bank untouched");

    // readback gated by input enable
    pad_in = 32'h0081_0003;
    idle(4);
    rd(8'h18, 32'h0, "R9 readback gated low");
    rd(8'h98, 32'h0, "R9 readback gated high");
    wr(8'h08, 32'h0000_FFFF);
    wr(8'h88, 32'h0000_FFFF);
    rd(8'h18, 32'h0000_0003, "R9 readback low");
    rd(8'h98, 32'h0000_0001, "R9 R7 readback high pin23 masked");
    rd(8'h1C, 32'h0, "R10 no capture while input disabled");

    // edge capture
    pad_in = 32'h0081_0007;
    idle(5);
    rd(8'h1C, 32'h0000_0004, "R10 rise pin2");
    rd(8'h20, 32'h0, "R10 no fall yet");
    pad_in = 32'h0081_0006;
    idle(5);
    rd(8'h20, 32'h0000_0001, "R10 fall pin0");
    pad_in = 32'h0080_0006;
    idle(5);
    rd(8'hA0, 32'h0000_0001, "R10 high bank fall pin16");
    pad_in = 32'h0000_0006;
    idle(5);
    rd(8'hA0, 32'h0000_0001, "R7 reserved pin23 no capture");

    // flag clearing
    wr(8'h1C, 32'h0000_0004);
    rd(8'h1C, 32'h0, "R11 rise clear");
    wr(8'h20, 32'h0001_0000);
    rd(8'h20, 32'h0000_0001, "R11 high half ignored");
    wr(8'h20, 32'h0000_0001);
    rd(8'h20, 32'h0, "R11 fall clear");

    // edge and clear reach the flag on the same clock
    @(negedge clk);
    pad_in = 32'h0000_000E;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 8'h1C; wdata = 32'h0000_0008;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    rd(8'h1C, 32'h0000_0008, "R11 set wins over clear");

    // ignored writes and unmapped reads
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, 32'h0000_000E, "R12 readback write ignored");
    wr(8'h05, 32'hFFFF_0000);
    rd(8'h04, 32'h0000_00E0, "R12 unaligned write ignored");
    wr(8'h40, 32'h0000_FFFF);
    rd(8'h40, 32'h0, "R12 unmapped read zero");
    rd(8'h00, 32'h0000_00A0, "R12 unmapped write no effect");

    idle(3);
    check("R6 scoreboard drained", 32'(sb_q.size()), 32'h0);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule